// File: doc/BRIEF.md
# Read-to-Acquire Hardware Semaphore

This block is a single-bit lock that several bus agents share, for example a host processor and a firmware controller that both program a common steering register. An agent takes the lock by reading it. The read answer arrives one cycle after the read. An answer of 1 means the reader is now the owner. An answer of 0 means the lock was held, or another agent won it in that cycle. The owner gives the lock back by writing a 1. A write of 0, and any write from an agent that does not own the lock, is dropped.

When more than one agent reads a free lock in the same cycle, the agent with the lowest index wins. The block drives the index of the current owner and a busy flag. Each agent port also has a polling engine. After a start pulse, the engine issues reads for its agent until one answer is 1, or until a fixed number of attempts has been used. It then raises a one-cycle won pulse or a one-cycle expired pulse.

Top module: `rdsem_top`

## Requirements
- R1: After reset the lock is free: `sem_busy` is 0, `owner_idx` is 0, no `bus_rvld` bit is set and no polling engine is active.
- R2: A read of a free lock by agent i sets `bus_rvld[i]` and `bus_rdata[i]` to 1 in the next cycle. From that same cycle on, `sem_busy` is 1 and `owner_idx` equals i.
- R3: A read while the lock is held returns `bus_rdata` 0 and leaves the owner unchanged. This also applies when the reader is the owner.
- R4: When several agents read a free lock in the same cycle, only the lowest-index reader gets 1 and becomes owner. Every other reader gets 0.
- R5: A write with `bus_wdata` 1 from the owner frees the lock in the next cycle. While the lock is free, `owner_idx` reads 0.
- R6: A write of 1 from a non-owner, a write of 0 from any agent, and any write while the lock is free all leave `sem_busy` and `owner_idx` unchanged.
- R7: When the owner releases in the same cycle that another agent reads, the read is judged against the held state and returns 0. The lock is free afterwards.
- R8: After a `poll_go[i]` pulse, engine i keeps reading for agent i. It raises `poll_won[i]` for one cycle after the first read answer of 1, and the agent then owns the lock.
- R9: If POLL_LIMIT consecutive answers to engine i are 0, the engine raises `poll_expired[i]` for one cycle, takes no ownership and goes idle. `poll_won` and `poll_expired` are never high together.
- R10: Every read, direct or from an engine, produces exactly one `bus_rvld` pulse in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | NUM_AGENTS | Read strobe per agent |
| bus_wr | input | NUM_AGENTS | Write strobe per agent |
| bus_wdata | input | NUM_AGENTS | Write data bit per agent; 1 means release |
| bus_rvld | output | NUM_AGENTS | Read answer valid, one cycle after the read |
| bus_rdata | output | NUM_AGENTS | Read answer; 1 means ownership granted |
| poll_go | input | NUM_AGENTS | Start pulse for the agent's polling engine |
| poll_active | output | NUM_AGENTS | Polling engine busy |
| poll_won | output | NUM_AGENTS | One-cycle pulse: engine acquired the lock |
| poll_expired | output | NUM_AGENTS | One-cycle pulse: attempts used up |
| owner_idx | output | OWNER_W | Binary index of the owner; 0 while free |
| sem_busy | output | 1 | Lock is held |

## Verification
Two pairs of functions can land in the same cycle. The first pair is two reads of a free lock. The stimulus table drives two or three read strobes together and expects exactly one 1 answer, on the lowest-index reader, and that reader as owner. The second pair is a release and a read. The table asserts the owner's write of 1 together with another agent's read, then expects a 0 answer and a free lock. The polling test uses the same overlap on purpose: the holder releases while an engine is polling, and the engine must still finish with a win on a later attempt.

// File: rtl/rdsem_pkg.sv
package rdsem_pkg;

    typedef enum logic [1:0] {
        POLL_IDLE  = 2'd0,
        POLL_ISSUE = 2'd1,
        POLL_WAIT  = 2'd2
    } poll_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rdsem_prio_arb.sv
module rdsem_prio_arb #(
    parameter int unsigned NUM_REQ = 3
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt
);

    logic [NUM_REQ:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_chain
        assign gnt[g]      = req[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req[g];
    end

endmodule

// File: rtl/rdsem_core.sv
module rdsem_core
    import rdsem_pkg::*;
#(
    parameter int unsigned NUM_AGENTS = 3,
    localparam int unsigned OWNER_W   = idx_width(NUM_AGENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] rd_req,
    input  logic [NUM_AGENTS-1:0] wr_req,
    input  logic [NUM_AGENTS-1:0] wr_bit,
    output logic [NUM_AGENTS-1:0] rsp_vld,
    output logic [NUM_AGENTS-1:0] rsp_bit,
    output logic [OWNER_W-1:0]    owner,
    output logic                  busy
);

    typedef struct packed {
        logic                  busy;
        logic [OWNER_W-1:0]    owner;
        logic [NUM_AGENTS-1:0] rvld;
        logic [NUM_AGENTS-1:0] rbit;
    } core_t;

    core_t q, d;
    logic [NUM_AGENTS-1:0] free_req;
    logic [NUM_AGENTS-1:0] gnt;
    logic                  rel;

    assign free_req = rd_req & {NUM_AGENTS{~q.busy}};

    rdsem_prio_arb #(.NUM_REQ(NUM_AGENTS)) u_arb (
        .req (free_req),
        .gnt (gnt)
    );

    always_comb begin
        d      = q;
        d.rvld = rd_req;
        d.rbit = gnt;
        rel    = 1'b0;
        for (int i = 0; i < NUM_AGENTS; i++) begin
            if (q.busy && (q.owner == OWNER_W'(i)) && wr_req[i] && wr_bit[i]) begin
                rel = 1'b1;
            end
        end
        if (q.busy) begin
            if (rel) begin
                d.busy  = 1'b0;
                d.owner = '0;
            end
        end else if (|gnt) begin
            d.busy = 1'b1;
            for (int i = 0; i < NUM_AGENTS; i++) begin
                if (gnt[i]) begin
                    d.owner = OWNER_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_vld = q.rvld;
    assign rsp_bit = q.rbit;
    assign owner   = q.owner;
    assign busy    = q.busy;

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_bit));

    assert_grant_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_bit) |-> busy);

    assert_free_stays_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_req == '0) |=> !busy);

    assert_owner_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_req & wr_bit) == '0) |=> (busy && $stable(owner)));

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_chk
        assert_held_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && rd_req[g]) |=> !rsp_bit[g]);

        assert_answer_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[g] |=> rsp_vld[g]);

        assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && owner == OWNER_W'(g) && wr_req[g] && wr_bit[g]) |=> !busy);
    end

endmodule

// File: rtl/rdsem_poller.sv
module rdsem_poller
    import rdsem_pkg::*;
#(
    parameter int unsigned POLL_LIMIT = 10,
    localparam int unsigned CNT_W     = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic rsp_vld,
    input  logic rsp_bit,
    output logic rd_out,
    output logic active,
    output logic won,
    output logic expired
);

    typedef struct packed {
        poll_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             won;
        logic             expired;
    } poll_t;

    poll_t q, d;

    always_comb begin
        d         = q;
        d.won     = 1'b0;
        d.expired = 1'b0;
        unique case (q.st)
            POLL_IDLE: begin
                if (go) begin
                    d.st  = POLL_ISSUE;
                    d.cnt = '0;
                end
            end
            POLL_ISSUE: begin
                d.st = POLL_WAIT;
            end
            POLL_WAIT: begin
                if (rsp_vld && rsp_bit) begin
                    d.won = 1'b1;
                    d.st  = POLL_IDLE;
                end else if (q.cnt == CNT_W'(POLL_LIMIT - 1)) begin
                    d.expired = 1'b1;
                    d.st      = POLL_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    d.st  = POLL_ISSUE;
                end
            end
            default: d.st = POLL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: POLL_IDLE, cnt: '0, won: 1'b0, expired: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_out  = (q.st == POLL_ISSUE);
    assign active  = (q.st != POLL_IDLE);
    assign won     = q.won;
    assign expired = q.expired;

    assert_won_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        won |-> $past(rsp_vld && rsp_bit));

    assert_outcomes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(won && expired));

    assert_read_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |=> rsp_vld);

endmodule

// File: rtl/rdsem_top.sv
module rdsem_top
    import rdsem_pkg::*;
#(
    parameter int unsigned NUM_AGENTS = 3,
    parameter int unsigned POLL_LIMIT = 10,
    localparam int unsigned OWNER_W   = idx_width(NUM_AGENTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] bus_rd,
    input  logic [NUM_AGENTS-1:0] bus_wr,
    input  logic [NUM_AGENTS-1:0] bus_wdata,
    output logic [NUM_AGENTS-1:0] bus_rvld,
    output logic [NUM_AGENTS-1:0] bus_rdata,
    input  logic [NUM_AGENTS-1:0] poll_go,
    output logic [NUM_AGENTS-1:0] poll_active,
    output logic [NUM_AGENTS-1:0] poll_won,
    output logic [NUM_AGENTS-1:0] poll_expired,
    output logic [OWNER_W-1:0]    owner_idx,
    output logic                  sem_busy
);

    logic [NUM_AGENTS-1:0] poll_rd;
    logic [NUM_AGENTS-1:0] merged_rd;

    assign merged_rd = bus_rd | poll_rd;

    rdsem_core #(.NUM_AGENTS(NUM_AGENTS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (merged_rd),
        .wr_req  (bus_wr),
        .wr_bit  (bus_wdata),
        .rsp_vld (bus_rvld),
        .rsp_bit (bus_rdata),
        .owner   (owner_idx),
        .busy    (sem_busy)
    );

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_poll
        rdsem_poller #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
            .clk     (clk),
            .rst_n   (rst_n),
            .go      (poll_go[g]),
            .rsp_vld (bus_rvld[g]),
            .rsp_bit (bus_rdata[g]),
            .rd_out  (poll_rd[g]),
            .active  (poll_active[g]),
            .won     (poll_won[g]),
            .expired (poll_expired[g])
        );
    end

endmodule

// File: tb/rdsem_top_tb.sv
module rdsem_top_tb;

    localparam int N     = 3;
    localparam int LIMIT = 10;
    localparam int OW    = 2;

    typedef struct packed {
        logic [N-1:0]  rd;
        logic [N-1:0]  wr;
        logic [N-1:0]  wd;
        logic [N-1:0]  e_vld;
        logic [N-1:0]  e_bit;
        logic          e_busy;
        logic [OW-1:0] e_own;
        logic [3:0]    tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'b001, 3'b000, 3'b000, 3'b001, 3'b001, 1'b1, 2'd0, 4'd2},  // R2 acquire by 0
        '{3'b010, 3'b000, 3'b000, 3'b010, 3'b000, 1'b1, 2'd0, 4'd3},  // R3 other reads held
        '{3'b001, 3'b000, 3'b000, 3'b001, 3'b000, 1'b1, 2'd0, 4'd3},  // R3 owner re-read
        '{3'b000, 3'b010, 3'b010, 3'b000, 3'b000, 1'b1, 2'd0, 4'd6},  // R6 non-owner write 1
        '{3'b000, 3'b001, 3'b000, 3'b000, 3'b000, 1'b1, 2'd0, 4'd6},  // R6 owner write 0
        '{3'b000, 3'b001, 3'b001, 3'b000, 3'b000, 1'b0, 2'd0, 4'd5},  // R5 release
        '{3'b000, 3'b100, 3'b100, 3'b000, 3'b000, 1'b0, 2'd0, 4'd6},  // R6 write while free
        '{3'b110, 3'b000, 3'b000, 3'b110, 3'b010, 1'b1, 2'd1, 4'd4},  // R4 two readers
        '{3'b100, 3'b010, 3'b010, 3'b100, 3'b000, 1'b0, 2'd0, 4'd7},  // R7 release + read
        '{3'b111, 3'b000, 3'b000, 3'b111, 3'b001, 1'b1, 2'd0, 4'd4},  // R4 three readers
        '{3'b000, 3'b001, 3'b001, 3'b000, 3'b000, 1'b0, 2'd0, 4'd5},  // R5 release
        '{3'b100, 3'b000, 3'b000, 3'b100, 3'b100, 1'b1, 2'd2, 4'd2},  // R2 acquire by 2
        '{3'b011, 3'b000, 3'b000, 3'b011, 3'b000, 1'b1, 2'd2, 4'd3},  // R3 two held reads
        '{3'b000, 3'b100, 3'b100, 3'b000, 3'b000, 1'b0, 2'd0, 4'd5}   // R5 release by 2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  bus_rd = '0, bus_wr = '0, bus_wdata = '0, poll_go = '0;
    logic [N-1:0]  bus_rvld, bus_rdata, poll_active, poll_won, poll_expired;
    logic [OW-1:0] owner_idx;
    logic          sem_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rdsem_top #(.NUM_AGENTS(N), .POLL_LIMIT(LIMIT)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rvld     (bus_rvld),
        .bus_rdata    (bus_rdata),
        .poll_go      (poll_go),
        .poll_active  (poll_active),
        .poll_won     (poll_won),
        .poll_expired (poll_expired),
        .owner_idx    (owner_idx),
        .sem_busy     (sem_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int reads;
        int outcome;
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held
        chk("R1", {29'd0, sem_busy, owner_idx}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {20'd0, bus_rvld, poll_active, poll_won, poll_expired}, 32'd0);
        chk("R1", {29'd0, sem_busy, owner_idx}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            bus_rd    = VEC[v].rd;
            bus_wr    = VEC[v].wr;
            bus_wdata = VEC[v].wd;
            @(negedge clk);
            bus_rd = '0; bus_wr = '0; bus_wdata = '0;
            chk($sformatf("R%0d vec%0d", VEC[v].tag, v),
                {20'd0, bus_rvld, bus_rdata, sem_busy, owner_idx, 3'd0},
                {20'd0, VEC[v].e_vld, VEC[v].e_bit, VEC[v].e_busy, VEC[v].e_own, 3'd0});
        end

        // R9 timeout: agent 0 holds, agent 1 polls without success
        bus_rd = 3'b001;
        @(negedge clk);
        bus_rd = '0;
        chk("R2", {30'd0, sem_busy, bus_rdata[0]}, 32'd3);
        poll_go = 3'b010;
        @(negedge clk);
        poll_go = '0;
        reads = 0;
        outcome = 0;
        for (int c = 0; c < 200 && outcome == 0; c++) begin
            @(negedge clk);
            if (bus_rvld[1]) reads++;
            if (poll_won[1] && poll_expired[1]) outcome = 3;
            else if (poll_won[1]) outcome = 1;
            else if (poll_expired[1]) outcome = 2;
        end
        chk("R9 outcome", outcome, 2);
        chk("R10 read count", reads, LIMIT);
        chk("R9 owner kept", {29'd0, sem_busy, owner_idx}, {29'd0, 1'b1, 2'd0});
        @(negedge clk);
        chk("R9 idle", {31'd0, poll_active[1]}, 32'd0);

        // R8 win: holder releases while agent 1 is polling
        poll_go = 3'b010;
        @(negedge clk);
        poll_go = '0;
        outcome = 0;
        for (int c = 0; c < 200 && outcome == 0; c++) begin
            if (c == 5) begin
                bus_wr = 3'b001; bus_wdata = 3'b001;
            end
            @(negedge clk);
            bus_wr = '0; bus_wdata = '0;
            if (poll_won[1] && poll_expired[1]) outcome = 3;
            else if (poll_won[1]) outcome = 1;
            else if (poll_expired[1]) outcome = 2;
        end
        chk("R8 outcome", outcome, 1);
        chk("R8 owner", {29'd0, sem_busy, owner_idx}, {29'd0, 1'b1, 2'd1});

        // R5 release by polled owner
        bus_wr = 3'b010; bus_wdata = 3'b010;
        @(negedge clk);
        bus_wr = '0; bus_wdata = '0;
        chk("R5 free", {29'd0, sem_busy, owner_idx}, 32'd0);

        report();
    end

endmodule